// File: doc/BRIEF.md
# Control-Word Driven Register File and ALU Datapath

This block is the execution datapath of a small processor. It holds seven general-purpose data registers and one ALU. A status register holds four flags. Every clock cycle a packed control word tells the datapath three things: which operands feed the ALU, which operation the ALU performs, and which register, if any, takes the result. An external sequencer or control store supplies the control words. That sequencer is not part of this block.

Each ALU operand comes from one of the seven registers or from an external input bus. The ALU result is combinational and always appears on the external output bus. On the rising clock edge the result is loaded into the selected destination register, and the flags are updated from the same result. A destination code of zero keeps every register unchanged while the result is still visible on the output. This lets the datapath act as a read port for its own registers, or pass external data straight through.

Top module: `regfile_alu_dp`

## Requirements
- R1: The control word is 14 bits wide and is split into fields as follows:
  - bits [13:11] select operand A;
  - bits [10:8] select operand B;
  - bits [7:5] select the destination;
  - bits [4:0] hold the operation code.
- R2: In both operand-select fields, codes 1 to 7 pick register 1 to 7, and code 0 picks the external input bus `ext_in`.
- R3: A destination code of 1 to 7 loads the ALU result into that register on the rising clock edge. All other registers keep their values.
- R4: A destination code of 0 loads no register. The result is still driven on `ext_out`.
- R5: `ext_out` always shows the current ALU result, combinationally from the control word, the registers and `ext_in`.
- R6: The operation codes are:

  | Code | Operation | Result |
  |------|-----------|--------|
  | 00000 | transfer | A |
  | 00001 | increment | A+1 |
  | 00010 | add | A+B |
  | 00101 | subtract | A+~B+1 |
  | 00110 | decrement | A+8'hFF |
  | 01000 | and | A&B |
  | 01010 | or | A\|B |
  | 01100 | xor | A^B |
  | 01110 | complement | ~A |
  | 10000 | shift right | A>>1, zero fill |
  | 11000 | shift left | A<<1, zero fill |

  XOR of a register with itself clears that register.
- R7: The output `flags` is {C,S,Z,V} on bits 3..0 and is updated on the clock edge.
  - S is result bit 7.
  - Z is 1 when the result is zero.
  - For the five arithmetic codes (transfer, increment, add, subtract, decrement), C is the carry out of bit 7 and V is that carry XOR the carry into bit 7.
  - Example: F0 minus 14 gives DC with flags 4'b1100.
- R8: For the logic codes (and, or, xor, complement), C and V are 0. For the shift codes, C takes the bit shifted out and V is 0.
- R9: Any other operation code gives a result of 0. That 0 is still loaded into the selected destination register, and the flags keep their previous value.
- R10: A synchronous active-high reset clears all seven registers and the flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_word | input | 14 | Packed control word {selA, selB, selD, opcode} |
| ext_in | input | 8 | External data, used as an operand when a select field is 0 |
| ext_out | output | 8 | Combinational ALU result |
| flags | output | 4 | Status register {C,S,Z,V} |

## Verification
The bench builds the block with its default parameters: 8-bit data and 3-bit select fields. This makes all seven registers and the shared zero code reachable in both operand fields and in the destination field. At this width the carry and overflow corners can be reached with short directed sequences:
- 7F+1 and 80-1, which overflow;
- decrementing 00 and 01, which cover the borrow and the zero result;
- shifts that move a one out of either end.

Register contents are read back by passing each register through the transfer operation with no destination selected.

// File: rtl/regfile_alu_dp.sv
module regfile_alu_dp #(
  parameter int DATA_W = 8,
  parameter int SEL_W  = 3,
  parameter int OPR_W  = 5,
  localparam int NREGS = (1 << SEL_W) - 1,
  localparam int CW_W  = 3 * SEL_W + OPR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CW_W-1:0]   ctrl_word,
  input  logic [DATA_W-1:0] ext_in,
  output logic [DATA_W-1:0] ext_out,
  output logic [3:0]        flags
);
  localparam int MSB = DATA_W - 1;
  localparam logic [OPR_W-1:0] OP_TSFA = OPR_W'(0);
  localparam logic [OPR_W-1:0] OP_INCA = OPR_W'(1);
  localparam logic [OPR_W-1:0] OP_ADD  = OPR_W'(2);
  localparam logic [OPR_W-1:0] OP_SUB  = OPR_W'(5);
  localparam logic [OPR_W-1:0] OP_DECA = OPR_W'(6);
  localparam logic [OPR_W-1:0] OP_AND  = OPR_W'(8);
  localparam logic [OPR_W-1:0] OP_OR   = OPR_W'(10);
  localparam logic [OPR_W-1:0] OP_XOR  = OPR_W'(12);
  localparam logic [OPR_W-1:0] OP_COMA = OPR_W'(14);
  localparam logic [OPR_W-1:0] OP_SHRA = OPR_W'(16);
  localparam logic [OPR_W-1:0] OP_SHLA = OPR_W'(24);

  logic [SEL_W-1:0] sel_a, sel_b, sel_d;
  logic [OPR_W-1:0] opr;
  assign {sel_a, sel_b, sel_d, opr} = ctrl_word;

  logic [NREGS:1][DATA_W-1:0] rf;
  logic [DATA_W-1:0] opa, opb, addend, res;
  logic [DATA_W:0]   sum;
  logic              cin, c_in_msb, c_f, v_f, res_ok;

  assign opa = (sel_a == '0) ? ext_in : rf[sel_a];
  assign opb = (sel_b == '0) ? ext_in : rf[sel_b];

  always_comb begin
    addend = '0;
    cin    = 1'b0;
    case (opr)
      OP_INCA: cin = 1'b1;
      OP_ADD:  addend = opb;
      OP_SUB:  begin addend = ~opb; cin = 1'b1; end
      OP_DECA: addend = '1;
      default: ;
    endcase
  end

  assign sum      = {1'b0, opa} + {1'b0, addend} + {{DATA_W{1'b0}}, cin};
  assign c_in_msb = opa[MSB] ^ addend[MSB] ^ sum[MSB];

  always_comb begin
    res    = '0;
    c_f    = 1'b0;
    v_f    = 1'b0;
    res_ok = 1'b1;
    case (opr)
      OP_TSFA, OP_INCA, OP_ADD, OP_SUB, OP_DECA: begin
        res = sum[MSB:0];
        c_f = sum[DATA_W];
        v_f = sum[DATA_W] ^ c_in_msb;
      end
      OP_AND:  res = opa & opb;
      OP_OR:   res = opa | opb;
      OP_XOR:  res = opa ^ opb;
      OP_COMA: res = ~opa;
      OP_SHRA: begin res = opa >> 1; c_f = opa[0]; end
      OP_SHLA: begin res = opa << 1; c_f = opa[MSB]; end
      default: res_ok = 1'b0;
    endcase
  end

  assign ext_out = res;

  for (genvar g = 1; g <= NREGS; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)                         rf[g] <= '0;
      else if (sel_d == SEL_W'(g))     rf[g] <= res;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         flags <= '0;
    else if (res_ok) flags <= {c_f, res[MSB], ~|res, v_f};
  end
endmodule

// File: rtl/regfile_alu_dp_chk.sv
module regfile_alu_dp_chk #(
  parameter int DATA_W = 8,
  parameter int SEL_W  = 3,
  parameter int OPR_W  = 5,
  parameter int NREGS  = 7
) (
  input logic                    clk,
  input logic                    rst,
  input logic [3*SEL_W+OPR_W-1:0] ctrl_word,
  input logic [DATA_W-1:0]       ext_in,
  input logic [DATA_W-1:0]       ext_out,
  input logic [3:0]              flags,
  input logic [NREGS*DATA_W-1:0] rf_flat
);
  logic [SEL_W-1:0] ca, cd;
  logic [OPR_W-1:0] co;
  logic known, is_logic;
  assign ca = ctrl_word[3*SEL_W+OPR_W-1 -: SEL_W];
  assign cd = ctrl_word[SEL_W+OPR_W-1 -: SEL_W];
  assign co = ctrl_word[OPR_W-1:0];
  assign is_logic = co == OPR_W'(8) || co == OPR_W'(10) || co == OPR_W'(12) || co == OPR_W'(14);
  assign known = co == OPR_W'(0) || co == OPR_W'(1) || co == OPR_W'(2) || co == OPR_W'(5) ||
                 co == OPR_W'(6) || is_logic || co == OPR_W'(16) || co == OPR_W'(24);

  // R9
  unused_hold_chk: assert property (@(posedge clk) disable iff (rst) !known |=> $stable(flags));
  // R9
  unused_zero_chk: assert property (@(posedge clk) disable iff (rst) !known |-> ext_out == '0);
  // R4
  no_dest_chk: assert property (@(posedge clk) disable iff (rst) cd == '0 |=> $stable(rf_flat));
  // R2
  ext_route_chk: assert property (@(posedge clk) disable iff (rst)
    (ca == '0 && co == '0) |-> ext_out == ext_in);
  // R7
  zero_flag_chk: assert property (@(posedge clk) disable iff (rst)
    known |=> flags[1] == ($past(ext_out) == '0));
  // R7
  sign_flag_chk: assert property (@(posedge clk) disable iff (rst)
    known |=> flags[2] == $past(ext_out[DATA_W-1]));
  // R8
  logic_cv_chk: assert property (@(posedge clk) disable iff (rst)
    is_logic |=> (flags[3] == 1'b0 && flags[0] == 1'b0));
endmodule

bind regfile_alu_dp regfile_alu_dp_chk #(
  .DATA_W(DATA_W), .SEL_W(SEL_W), .OPR_W(OPR_W), .NREGS(NREGS)
) u_chk (
  .clk(clk), .rst(rst), .ctrl_word(ctrl_word), .ext_in(ext_in),
  .ext_out(ext_out), .flags(flags), .rf_flat(rf)
);

// File: tb/regfile_alu_dp_bench.sv
module regfile_alu_dp_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [13:0] cw = '0;
  logic [7:0] ext_in = '0;
  logic [7:0] ext_out;
  logic [3:0] flags;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  localparam logic [4:0] TSFA = 5'd0, INCA = 5'd1, ADD = 5'd2, SUB = 5'd5, DECA = 5'd6,
                         LAND = 5'd8, LOR = 5'd10, LXOR = 5'd12, COMA = 5'd14,
                         SHRA = 5'd16, SHLA = 5'd24;

  always #4 clk = ~clk;

  regfile_alu_dp u_regfile_alu_dp (.clk(clk), .rst(rst), .ctrl_word(cw), .ext_in(ext_in),
                                   .ext_out(ext_out), .flags(flags));

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic op(input logic [2:0] a, input logic [2:0] b, input logic [2:0] d,
                    input logic [4:0] o, input logic [7:0] ein,
                    output logic [7:0] r, output logic [3:0] f);
    @(negedge clk);
    cw = {a, b, d, o};
    ext_in = ein;
    #1 r = ext_out;
    @(posedge clk);
    #1 f = flags;
  endtask

  task automatic rd(input logic [2:0] k, output logic [7:0] r);
    logic [3:0] f;
    op(k, 3'd0, 3'd0, TSFA, 8'h00, r, f);
  endtask

  task automatic t_reset;
    logic [7:0] r;
    rst = 1'b1;
    repeat (2) @(posedge clk);
    #1 chk("R10 flags", {4'h0, flags}, 8'h00);
    @(negedge clk) rst = 1'b0;
    for (int k = 1; k <= 7; k++) begin
      rd(3'(k), r);
      chk($sformatf("R10 reg %0d cleared", k), r, 8'h00);
    end
  endtask

  task automatic t_load;
    logic [7:0] r; logic [3:0] f;
    for (int k = 1; k <= 7; k++) begin
      op(3'd0, 3'd0, 3'(k), TSFA, 8'(k * 17), r, f);
      chk("R5 ext_out transfer", r, 8'(k * 17));
    end
    for (int k = 1; k <= 7; k++) begin
      rd(3'(k), r);
      chk($sformatf("R3 R2 reg %0d readback", k), r, 8'(k * 17));
    end
    op(3'd1, 3'd0, 3'd0, ADD, 8'h22, r, f);
    chk("R1 R2 selB ext add", r, 8'h33);
    chk("R7 add flags", {4'h0, f}, 8'h00);
    op(3'd1, 3'd2, 3'd0, ADD, 8'h00, r, f);
    chk("R1 reg+reg add", r, 8'h33);
  endtask

  task automatic t_nodest;
    logic [7:0] r; logic [3:0] f;
    op(3'd0, 3'd0, 3'd0, TSFA, 8'hA5, r, f);
    chk("R4 ext_out with no dest", r, 8'hA5);
    for (int k = 1; k <= 7; k++) begin
      rd(3'(k), r);
      chk($sformatf("R4 reg %0d untouched", k), r, 8'(k * 17));
    end
  endtask

  task automatic t_arith;
    logic [7:0] r; logic [3:0] f;
    op(3'd0, 3'd0, 3'd2, TSFA, 8'hF0, r, f);
    op(3'd0, 3'd0, 3'd3, TSFA, 8'h14, r, f);
    op(3'd2, 3'd3, 3'd1, SUB, 8'h00, r, f);
    chk("R6 sub F0-14", r, 8'hDC);
    chk("R7 sub flags", {4'h0, f}, 8'h0C);
    rd(3'd1, r);
    chk("R3 sub written to reg1", r, 8'hDC);
    op(3'd2, 3'd3, 3'd0, ADD, 8'h00, r, f);
    chk("R6 add F0+14", r, 8'h04);
    chk("R7 add carry flags", {4'h0, f}, 8'h08);
    op(3'd0, 3'd0, 3'd4, TSFA, 8'h7F, r, f);
    op(3'd4, 3'd0, 3'd4, INCA, 8'h00, r, f);
    chk("R6 inc 7F", r, 8'h80);
    chk("R7 inc overflow flags", {4'h0, f}, 8'h05);
    op(3'd0, 3'd0, 3'd0, DECA, 8'h00, r, f);
    chk("R6 dec 00", r, 8'hFF);
    chk("R7 dec 00 flags", {4'h0, f}, 8'h04);
    op(3'd0, 3'd0, 3'd0, DECA, 8'h01, r, f);
    chk("R6 dec 01", r, 8'h00);
    chk("R7 dec 01 flags", {4'h0, f}, 8'h0A);
    op(3'd0, 3'd0, 3'd7, TSFA, 8'h01, r, f);
    op(3'd0, 3'd7, 3'd0, SUB, 8'h80, r, f);
    chk("R6 sub 80-01", r, 8'h7F);
    chk("R7 sub overflow flags", {4'h0, f}, 8'h09);
  endtask

  task automatic t_logic;
    logic [7:0] r; logic [3:0] f;
    op(3'd5, 3'd5, 3'd5, LXOR, 8'h00, r, f);
    chk("R6 xor self", r, 8'h00);
    chk("R8 xor flags", {4'h0, f}, 8'h02);
    rd(3'd5, r);
    chk("R6 reg5 cleared", r, 8'h00);
    op(3'd2, 3'd3, 3'd0, ADD, 8'h00, r, f);
    op(3'd0, 3'd2, 3'd0, LAND, 8'hFF, r, f);
    chk("R6 and", r, 8'hF0);
    chk("R8 and clears C", {4'h0, f}, 8'h04);
    op(3'd0, 3'd3, 3'd0, LOR, 8'h0F, r, f);
    chk("R6 or", r, 8'h1F);
    chk("R8 or flags", {4'h0, f}, 8'h00);
    op(3'd0, 3'd0, 3'd0, COMA, 8'h0F, r, f);
    chk("R6 complement", r, 8'hF0);
    chk("R8 complement flags", {4'h0, f}, 8'h04);
  endtask

  task automatic t_shift;
    logic [7:0] r; logic [3:0] f;
    op(3'd0, 3'd0, 3'd0, SHRA, 8'h81, r, f);
    chk("R6 shr", r, 8'h40);
    chk("R8 shr carry", {4'h0, f}, 8'h08);
    op(3'd0, 3'd0, 3'd0, SHLA, 8'h81, r, f);
    chk("R6 shl", r, 8'h02);
    chk("R8 shl carry", {4'h0, f}, 8'h08);
    op(3'd0, 3'd0, 3'd0, SHLA, 8'h40, r, f);
    chk("R6 shl into sign", r, 8'h80);
    chk("R8 shl flags", {4'h0, f}, 8'h04);
  endtask

  task automatic t_unused;
    logic [7:0] r; logic [3:0] f;
    op(3'd2, 3'd3, 3'd0, SUB, 8'h00, r, f);
    op(3'd0, 3'd0, 3'd6, 5'd3, 8'hA5, r, f);
    chk("R9 unused result zero", r, 8'h00);
    chk("R9 unused keeps flags", {4'h0, f}, 8'h0C);
    op(3'd0, 3'd0, 3'd0, 5'd31, 8'h5A, r, f);
    chk("R9 code 31 result", r, 8'h00);
    chk("R9 code 31 keeps flags", {4'h0, f}, 8'h0C);
    rd(3'd6, r);
    chk("R9 dest loaded with zero", r, 8'h00);
  endtask

  initial begin
    t_reset();
    t_load();
    t_nodest();
    t_arith();
    t_logic();
    t_shift();
    t_unused();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule